// File: doc/BRIEF.md
# Direct-Mapped Translation Buffer with Queued Page Walks

This block turns a 39-bit virtual address into a 56-bit physical address for one access class. One copy of the block is placed for instruction fetch, one for loads and one for stores, and each copy keeps its own entry array. Entries are direct-mapped: the low bits of the virtual page number pick the slot, and the remaining bits are stored as the tag. A lookup that finds a valid matching entry answers on the next clock edge.

On a miss the block walks a three-level page table whose root page number comes from `root_ppn`. Each page-table-entry read goes out as its own request on the `pw_req_*` port, toward a shared memory request queue. The request carries the byte address of the entry. The block waits for the matching `pw_rsp_*` response before it moves to the next level. When the walk ends, the block either refills the slot and returns the translation, or reports a page fault. A one-cycle `inv_all` pulse empties the whole array.

Top module: `dm_xlat_tlb`

## Requirements
- R1: The slot index is VPN[3:0] (the VPN is vaddr[38:12], with 16 slots by default) and the tag is the rest of the VPN. A refill replaces only the entry at its own index, so two pages that share an index evict each other, while pages at other indices stay resident.
- R2: When an accepted request hits, `xl_done` rises in the cycle right after acceptance and no memory request is issued.
- R3: A miss issues one read per level, in the order level 2, then 1, then 0. Each read address is base_ppn*4096 + VPN_slice*8. VPN slice 2 is VPN[26:18], slice 1 is VPN[17:9] and slice 0 is VPN[8:0]. The first base is `root_ppn`, and each later base is the page number of the previous entry.
- R4: `pw_req_valid` stays high with a stable `pw_req_addr` until `pw_req_ready` is sampled high. After each accepted read, the block waits for `pw_rsp_valid` before it issues anything more.
- R5: An entry counts as a leaf when bit 1 (read) or bit 3 (execute) is set. Its page number is bits 53:10 of the entry, and the result is {ppn, vaddr[11:0]}. An entry with only bit 2 (write) set beside bit 0 (valid) is not a leaf.
- R6: An entry with bit 0 (valid) clear ends the walk at once with a fault, and no further reads follow. A non-leaf entry at level 0 also faults. On a fault, `xl_fault` is 1 and `xl_paddr` is 0.
- R7: Only a walk that succeeds writes the array. A faulting walk leaves the entry already held at its index usable as a hit.
- R8: A one-cycle `inv_all` pulse clears every entry, so every following lookup walks again.
- R9: `xl_ready` is high out of reset and while idle. It is low from the cycle after a miss is accepted until the result is returned, and the block issues no memory request while `xl_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_all | input | 1 | Clear every entry |
| root_ppn | input | 44 | Page number of the top-level table, sampled when a walk starts |
| xl_valid | input | 1 | Translation request |
| xl_ready | output | 1 | Block can accept a request |
| xl_vaddr | input | 39 | Virtual address to translate |
| xl_done | output | 1 | One-cycle result strobe |
| xl_fault | output | 1 | Result is a page fault |
| xl_paddr | output | 56 | Translated physical address (0 on fault) |
| pw_req_valid | output | 1 | Table-entry read request |
| pw_req_ready | input | 1 | Queue accepts the request |
| pw_req_addr | output | 56 | Byte address of the table entry |
| pw_rsp_valid | input | 1 | Read data strobe |
| pw_rsp_data | input | 64 | Table entry returned |

## Verification
The assertions assume that the memory side returns exactly one `pw_rsp_valid` pulse for each accepted read, and only after that read was accepted. They also assume that `root_ppn` does not change during a walk. The bench's memory responder answers each accepted read once, after a random delay of one to three cycles, and it toggles `pw_req_ready` at random so that the hold behaviour is exercised. `inv_all` and changes to the page table happen only between translations, never while a request or a walk is in flight.

// File: rtl/dmxt_pkg.sv
package dmxt_pkg;
    localparam int PG_OFF_W = 12;
    localparam int SLICE_W  = 9;
    localparam int LEVELS   = 3;
    localparam int VPN_W    = SLICE_W * LEVELS;
    localparam int VA_W     = VPN_W + PG_OFF_W;
    localparam int PPN_W    = 44;
    localparam int PA_W     = PPN_W + PG_OFF_W;
    localparam int PTE_W    = 64;
    localparam int PTE_PPN_LO = 10;
    localparam int BIT_V    = 0;
    localparam int BIT_R    = 1;
    localparam int BIT_X    = 3;
    localparam int LVL_W    = 2;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_ISSUE = 2'd1,
        WK_WAIT  = 2'd2
    } walk_st_e;
endpackage

// File: rtl/dmxt_store.sv
module dmxt_store
    import dmxt_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int TAG_W   = VPN_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PPN_W-1:0] rd_ppn,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PPN_W-1:0] wr_ppn
);
    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } slot_t;

    slot_t slot_d [ENTRIES];
    slot_t slot_q [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        always_comb begin
            slot_d[i] = slot_q[i];
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                slot_d[i].valid = 1'b1;
                slot_d[i].tag   = wr_tag;
                slot_d[i].ppn   = wr_ppn;
            end
            if (flush) begin
                slot_d[i].valid = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else begin
                slot_q[i] <= slot_d[i];
            end
        end
    end

    always_comb begin
        rd_valid = slot_q[rd_idx].valid;
        rd_tag   = slot_q[rd_idx].tag;
        rd_ppn   = slot_q[rd_idx].ppn;
    end
endmodule

// File: rtl/dmxt_walk.sv
module dmxt_walk
    import dmxt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VPN_W-1:0] start_vpn,
    input  logic [PPN_W-1:0] root_ppn,
    output logic             busy,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             done,
    output logic             fault,
    output logic [PPN_W-1:0] leaf_ppn
);
    typedef struct packed {
        walk_st_e         st;
        logic [LVL_W-1:0] lvl;
        logic [PPN_W-1:0] base;
        logic [VPN_W-1:0] vpn;
    } walk_regs_t;

    walk_regs_t r_d, r_q;
    logic [SLICE_W-1:0] slice;
    logic [PPN_W-1:0]   pte_ppn;
    logic               unused_pte;

    assign pte_ppn    = mem_rsp_data[PTE_PPN_LO +: PPN_W];
    assign unused_pte = ^{mem_rsp_data[PTE_W-1:PTE_PPN_LO+PPN_W],
                          mem_rsp_data[PTE_PPN_LO-1:BIT_X+1], mem_rsp_data[BIT_X-1]};

    always_comb begin
        case (r_q.lvl)
            2'd2:    slice = r_q.vpn[2*SLICE_W +: SLICE_W];
            2'd1:    slice = r_q.vpn[SLICE_W +: SLICE_W];
            default: slice = r_q.vpn[0 +: SLICE_W];
        endcase
    end

    assign busy          = (r_q.st != WK_IDLE);
    assign mem_req_valid = (r_q.st == WK_ISSUE);
    assign mem_req_addr  = {r_q.base, slice, 3'b000};

    always_comb begin
        r_d      = r_q;
        done     = 1'b0;
        fault    = 1'b0;
        leaf_ppn = pte_ppn;
        case (r_q.st)
            WK_IDLE: begin
                if (start) begin
                    r_d.st   = WK_ISSUE;
                    r_d.lvl  = LVL_W'(LEVELS - 1);
                    r_d.base = root_ppn;
                    r_d.vpn  = start_vpn;
                end
            end
            WK_ISSUE: begin
                if (mem_req_ready) begin
                    r_d.st = WK_WAIT;
                end
            end
            WK_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!mem_rsp_data[BIT_V]) begin
                        done     = 1'b1;
                        fault    = 1'b1;
                        r_d.st   = WK_IDLE;
                    end else if (mem_rsp_data[BIT_R] || mem_rsp_data[BIT_X]) begin
                        done     = 1'b1;
                        r_d.st   = WK_IDLE;
                    end else if (r_q.lvl == '0) begin
                        done     = 1'b1;
                        fault    = 1'b1;
                        r_d.st   = WK_IDLE;
                    end else begin
                        r_d.base = pte_ppn;
                        r_d.lvl  = r_q.lvl - LVL_W'(1);
                        r_d.st   = WK_ISSUE;
                    end
                end
            end
            default: r_d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: WK_IDLE, lvl: '0, base: '0, vpn: '0};
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/dm_xlat_tlb.sv
module dm_xlat_tlb
    import dmxt_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_all,
    input  logic [43:0]      root_ppn,
    input  logic             xl_valid,
    output logic             xl_ready,
    input  logic [38:0]      xl_vaddr,
    output logic             xl_done,
    output logic             xl_fault,
    output logic [55:0]      xl_paddr,
    output logic             pw_req_valid,
    input  logic             pw_req_ready,
    output logic [55:0]      pw_req_addr,
    input  logic             pw_rsp_valid,
    input  logic [63:0]      pw_rsp_data
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = VPN_W - IDX_W;

    typedef struct packed {
        logic            done;
        logic            fault;
        logic [PA_W-1:0] paddr;
        logic [VA_W-1:0] pend_va;
    } top_regs_t;

    top_regs_t t_d, t_q;

    logic [VPN_W-1:0] in_vpn;
    logic [IDX_W-1:0] in_idx;
    logic [TAG_W-1:0] in_tag;
    logic             rd_valid;
    logic [TAG_W-1:0] rd_tag;
    logic [PPN_W-1:0] rd_ppn;
    logic             hit;
    logic             accept;
    logic             wk_busy, wk_done, wk_fault;
    logic [PPN_W-1:0] wk_ppn;
    logic             fill_en;
    logic [VPN_W-1:0] pend_vpn;

    assign in_vpn   = xl_vaddr[VA_W-1:PG_OFF_W];
    assign in_idx   = in_vpn[IDX_W-1:0];
    assign in_tag   = in_vpn[VPN_W-1:IDX_W];
    assign pend_vpn = t_q.pend_va[VA_W-1:PG_OFF_W];
    assign hit      = rd_valid && (rd_tag == in_tag);
    assign xl_ready = !wk_busy;
    assign accept   = xl_valid && xl_ready;
    assign fill_en  = wk_done && !wk_fault;

    dmxt_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (inv_all),
        .rd_idx   (in_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_ppn   (rd_ppn),
        .wr_en    (fill_en),
        .wr_idx   (pend_vpn[IDX_W-1:0]),
        .wr_tag   (pend_vpn[VPN_W-1:IDX_W]),
        .wr_ppn   (wk_ppn)
    );

    dmxt_walk u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (accept && !hit),
        .start_vpn     (in_vpn),
        .root_ppn      (root_ppn),
        .busy          (wk_busy),
        .mem_req_valid (pw_req_valid),
        .mem_req_ready (pw_req_ready),
        .mem_req_addr  (pw_req_addr),
        .mem_rsp_valid (pw_rsp_valid),
        .mem_rsp_data  (pw_rsp_data),
        .done          (wk_done),
        .fault         (wk_fault),
        .leaf_ppn      (wk_ppn)
    );

    always_comb begin
        t_d       = t_q;
        t_d.done  = 1'b0;
        t_d.fault = 1'b0;
        if (accept) begin
            if (hit) begin
                t_d.done  = 1'b1;
                t_d.paddr = {rd_ppn, xl_vaddr[PG_OFF_W-1:0]};
            end else begin
                t_d.pend_va = xl_vaddr;
            end
        end
        if (wk_done) begin
            t_d.done  = 1'b1;
            t_d.fault = wk_fault;
            t_d.paddr = wk_fault ? '0 : {wk_ppn, t_q.pend_va[PG_OFF_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign xl_done  = t_q.done;
    assign xl_fault = t_q.fault;
    assign xl_paddr = t_q.paddr;
endmodule

// File: rtl/dmxt_chk.sv
module dmxt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        xl_valid,
    input logic        xl_ready,
    input logic        xl_done,
    input logic        xl_fault,
    input logic [55:0] xl_paddr,
    input logic        pw_req_valid,
    input logic        pw_req_ready,
    input logic [55:0] pw_req_addr
);
    // R2: an accepted request is answered next cycle or has started a walk
    assert_hit_or_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid && xl_ready |=> xl_done || !xl_ready);

    // R4: a pending request holds its address until taken
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pw_req_valid && !pw_req_ready |=> pw_req_valid && $stable(pw_req_addr));

    // R3: table-entry addresses are 8-byte aligned
    assert_pte_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pw_req_valid |-> pw_req_addr[2:0] == 3'b000);

    // R9: no memory traffic while the block is idle
    assert_no_req_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pw_req_valid |-> !xl_ready);

    // R9: a result is presented only once the block is idle again
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xl_done |-> xl_ready);

    // R6: a fault carries a zero address and the result strobe
    assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault |-> xl_done && (xl_paddr == 56'd0));
endmodule

bind dm_xlat_tlb dmxt_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xl_valid     (xl_valid),
    .xl_ready     (xl_ready),
    .xl_done      (xl_done),
    .xl_fault     (xl_fault),
    .xl_paddr     (xl_paddr),
    .pw_req_valid (pw_req_valid),
    .pw_req_ready (pw_req_ready),
    .pw_req_addr  (pw_req_addr)
);

// File: tb/sim_dm_xlat_tlb.sv
`timescale 1ns/1ps
module sim_dm_xlat_tlb;
    localparam int EN    = 16;
    localparam int IDXW  = 4;
    localparam int TAGW  = 27 - IDXW;
    localparam logic [43:0] ROOT = 44'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inv_all = 1'b0;
    logic [43:0] root_ppn = ROOT;
    logic        xl_valid = 1'b0;
    logic        xl_ready;
    logic [38:0] xl_vaddr = '0;
    logic        xl_done, xl_fault;
    logic [55:0] xl_paddr;
    logic        pw_req_valid;
    logic        pw_req_ready = 1'b0;
    logic [55:0] pw_req_addr;
    logic        pw_rsp_valid = 1'b0;
    logic [63:0] pw_rsp_data = '0;

    always #2 clk = ~clk;

    dm_xlat_tlb #(.ENTRIES(EN)) u0 (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .root_ppn(root_ppn),
        .xl_valid(xl_valid), .xl_ready(xl_ready), .xl_vaddr(xl_vaddr),
        .xl_done(xl_done), .xl_fault(xl_fault), .xl_paddr(xl_paddr),
        .pw_req_valid(pw_req_valid), .pw_req_ready(pw_req_ready),
        .pw_req_addr(pw_req_addr), .pw_rsp_valid(pw_rsp_valid),
        .pw_rsp_data(pw_rsp_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 0;

    logic [63:0] pt [logic [55:0]];
    logic [43:0] next_ppn = 44'h200;

    bit          mv [EN];
    logic [TAGW-1:0] mt [EN];
    logic [43:0] mp [EN];

    logic [55:0] got_q [$];
    int          reads = 0;
    int          rsp_cnt = 0;
    logic [55:0] pend_a = '0;

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic logic [63:0] pte_at(input logic [55:0] a);
        return pt.exists(a) ? pt[a] : 64'd0;
    endfunction

    task automatic map_page(input logic [26:0] vpn, input logic [43:0] ppn, input logic [9:0] flags);
        logic [43:0] base = ROOT;
        logic [55:0] a;
        for (int l = 2; l >= 1; l--) begin
            a = {base, vpn[l*9 +: 9], 3'b000};
            if (!pt.exists(a)) begin
                pt[a] = {10'd0, next_ppn, 10'h001};
                next_ppn++;
            end
            base = pt[a][53:10];
        end
        a = {base, vpn[8:0], 3'b000};
        pt[a] = {10'd0, ppn, flags};
    endtask

    task automatic model_walk(input logic [26:0] vpn, output bit f, output logic [43:0] p,
                              output int n, output logic [55:0] ea [3]);
        logic [43:0] base = ROOT;
        logic [55:0] a;
        logic [63:0] e;
        f = 0; p = '0; n = 0;
        for (int k = 0; k < 3; k++) ea[k] = '0;
        for (int l = 2; l >= 0; l--) begin
            a = {base, vpn[l*9 +: 9], 3'b000};
            ea[n] = a;
            n++;
            e = pte_at(a);
            if (!e[0]) begin f = 1; return; end
            if (e[1] || e[3]) begin p = e[53:10]; return; end
            if (l == 0) begin f = 1; return; end
            base = e[53:10];
        end
    endtask

    // memory responder: one answer per accepted read, random delay and ready
    initial begin
        forever begin
            @(negedge clk);
            pw_rsp_valid = 1'b0;
            pw_req_ready = ($urandom % 4) != 0;
            if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    pw_rsp_valid = 1'b1;
                    pw_rsp_data  = pte_at(pend_a);
                end
            end else if (rst_n && pw_req_valid && pw_req_ready) begin
                pend_a  = pw_req_addr;
                got_q.push_back(pw_req_addr);
                reads++;
                rsp_cnt = 1 + int'($urandom % 3);
            end
        end
    end

    task automatic xlat(input logic [38:0] va, input string rq);
        logic [26:0] vpn = va[38:12];
        int idx = int'(vpn[IDXW-1:0]);
        logic [TAGW-1:0] tg = vpn[26:IDXW];
        bit ehit, ef;
        logic [43:0] ep;
        int en, cyc;
        logic [55:0] ea [3];
        logic [55:0] exp_pa;
        ehit = mv[idx] && (mt[idx] == tg);
        if (ehit) begin
            ef = 0; ep = mp[idx]; en = 0;
            for (int k = 0; k < 3; k++) ea[k] = '0;
        end else begin
            model_walk(vpn, ef, ep, en, ea);
        end
        exp_pa = ef ? 56'd0 : {ep, va[11:0]};
        @(negedge clk);
        while (!xl_ready) @(negedge clk);
        got_q.delete();
        reads = 0;
        xl_valid = 1'b1;
        xl_vaddr = va;
        @(negedge clk);
        xl_valid = 1'b0;
        cyc = 1;
        if (!ehit) chk(xl_ready == 1'b0, {rq, " R9 ready low during walk"}, 64'(xl_ready), 64'd0);
        while (!xl_done && cyc < 500) begin
            @(negedge clk);
            cyc++;
        end
        chk(xl_done == 1'b1, {rq, " result returned"}, 64'(xl_done), 64'd1);
        if (ehit) chk(cyc == 1, {rq, " R2 hit latency"}, 64'(cyc), 64'd1);
        chk(xl_fault == ef, {rq, " R6 fault flag"}, 64'(xl_fault), 64'(ef));
        chk(xl_paddr == exp_pa, {rq, " R5 physical address"}, 64'(xl_paddr), 64'(exp_pa));
        chk(reads == en, {rq, " R3 read count"}, 64'(reads), 64'(en));
        for (int k = 0; k < en; k++) begin
            if (k < got_q.size())
                chk(got_q[k] == ea[k], {rq, " R3 entry address"}, 64'(got_q[k]), 64'(ea[k]));
        end
        if (!ehit && !ef) begin
            mv[idx] = 1; mt[idx] = tg; mp[idx] = ep;
        end
    endtask

    task automatic flush_all();
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        for (int i = 0; i < EN; i++) mv[i] = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
        finish_up();
    end

    initial begin
        logic [26:0] pool [40];
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < EN; i++) mv[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(xl_done == 1'b0, "R9 reset done low", 64'(xl_done), 64'd0);
        chk(pw_req_valid == 1'b0, "R9 reset no request", 64'(pw_req_valid), 64'd0);
        chk(xl_ready == 1'b1, "R9 reset ready", 64'(xl_ready), 64'd1);

        // R3 / R2: first access walks three levels, second hits
        map_page(27'h0_0003, 44'hABC01, 10'h00F);
        xlat({27'h0_0003, 12'h123}, "R3 first miss");
        xlat({27'h0_0003, 12'hFF8}, "R2 second hit");

        // R1: same index evicts, other index survives
        map_page(27'h0_0013, 44'hABC02, 10'h00F);
        map_page(27'h0_0005, 44'hABC03, 10'h00F);
        xlat({27'h0_0005, 12'h010}, "R1 other index fill");
        xlat({27'h0_0013, 12'h020}, "R1 conflicting fill");
        xlat({27'h0_0003, 12'h030}, "R1 evicted page walks");
        xlat({27'h0_0005, 12'h040}, "R1 other index still hits");

        // R5: execute-only and read-only leaves; write-only is not a leaf
        map_page(27'h0_0106, 44'h11111, 10'h009);
        map_page(27'h0_0107, 44'h22222, 10'h003);
        map_page(27'h0_0108, 44'h33333, 10'h005);
        xlat({27'h0_0106, 12'h001}, "R5 execute leaf");
        xlat({27'h0_0107, 12'h002}, "R5 read leaf");
        xlat({27'h0_0108, 12'h003}, "R5 write-only faults");

        // R6: missing top-level entry faults after one read
        xlat({27'h7_FC09, 12'h004}, "R6 invalid top entry");
        // R6: non-leaf at level 0
        map_page(27'h0_000A, 44'h44444, 10'h001);
        xlat({27'h0_000A, 12'h005}, "R6 pointer at last level");

        // R7: a fault at an occupied index keeps the old entry
        xlat({27'h0_0005, 12'h006}, "R7 resident entry");
        xlat({27'h0_0035, 12'h007}, "R7 faulting walk same index");
        xlat({27'h0_0005, 12'h008}, "R7 entry survives fault");

        // R8: invalidate clears everything
        flush_all();
        xlat({27'h0_0005, 12'h009}, "R8 walk after invalidate");
        xlat({27'h0_0106, 12'h00A}, "R8 second page walks");

        // random traffic
        for (int i = 0; i < 40; i++) begin
            pool[i] = {9'($urandom % 4), 9'($urandom % 8), 9'($urandom)};
            if (i < 30) map_page(pool[i], 44'($urandom) | 44'h1000, (i % 3 == 0) ? 10'h009 : 10'h00F);
        end
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 50) == 0) flush_all();
            xlat({pool[$urandom % 40], 12'($urandom)}, "R1 R3 random");
        end

        finish_up();
    end
endmodule